// File: doc/BRIEF.md
# Accumulator Move Path with Scaling and Limiting

This block sits between the wide accumulator of a fixed-point DSP core and the narrower registers and memory words around it. On the read side, the full accumulator (guard bits, high word and low word) passes through a one-position scaler chosen by a two-bit mode. The block then looks at the guard bits above the high-word window. If they show that the value no longer fits in a data word, the output is clamped to the most positive or most negative data word. The result is delivered either as a full data word or as a short word that keeps only the low bits. Every clamp also sets a sticky limit flag, which stays set until a synchronous clear. A read that selects a single sub-register (guard, high or low part) bypasses both scaling and limiting.

On the write side, the block formats an operand for one of four destinations: the full accumulator, the high or low sub-register of the accumulator, or a plain data-word register. A data word written to the full accumulator is sign-extended into the guard bits and gets a zero low word. A short operand is first zero-filled to a data word. A write to a sub-register replaces only that part and keeps the rest of the current accumulator value. Read and write results are both registered with one cycle of latency, and the two paths can be used in the same cycle.

Top module: `acc_move_path`

## Requirements
- R1: For a full-accumulator read, the result is the high-word window of the scaled accumulator. The scaling modes on `scale_mode` are: 00 no shift, 01 arithmetic right shift by one, 10 left shift by one, 11 no shift.
- R2: A full read to a data-word destination is clamped when the scaled bits from the top of the accumulator down to the window's top bit are not all equal. The clamp value is 0x7FFFFF when the sign is positive and 0x800000 when it is negative, both at the default width.
- R3: With `rd_short` set, the result carries only the low SHORT_W bits of the clamped or unclamped value, and the upper bits of `rd_data` are zero. The clamp gives 0xFFFF for positive and 0x0000 for negative at the default widths.
- R4: `limit_flag` is set by every accepted clamping read (`rd_valid` high) and stays set until cleared. A read without `rd_valid` leaves both the flag and `rd_out_valid` untouched.
- R5: `limit_clr` clears the flag in the next cycle. A clamping read in the same cycle wins, and the flag stays set.
- R6: `rd_src` selects the source: 0 full, 1 guard bits (sign-extended to a data word), 2 high word, 3 low word. Sub-register sources are neither scaled nor clamped, and they leave `limit_flag` unchanged.
- R7: `wr_dst` selects the destination: 0 full accumulator, 1 high word, 2 low word, 3 data-word register. A data word written to the full accumulator is sign-extended from its top bit through the guard bits, and the low word is zero.
- R8: With `wr_short` set, the operand's low SHORT_W bits are placed in the low part of a data word and the bits above are zero, for the register, high-word and low-word destinations.
- R9: A short operand written to the full accumulator becomes the zero-filled data word in the high part, sign-extended from that word's top bit, with a zero low word.
- R10: A write to the high or low sub-register replaces only that part. All other bits of `acc_wr_data` equal `acc_in` from the cycle of the write.
- R11: After reset, all outputs are zero. `rd_out_valid`, `acc_wr_en` and `reg_wr_en` follow the accepted request with one cycle of latency. The accumulator destinations raise only `acc_wr_en`, and the register destination raises only `reg_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scale_mode | input | 2 | Scaling mode for full reads |
| acc_in | input | EXT_W+2*DATA_W | Current accumulator value (read source and write merge base) |
| rd_valid | input | 1 | Read request |
| rd_src | input | 2 | Read source select |
| rd_short | input | 1 | Read destination is a short word |
| rd_data | output | DATA_W | Registered read result |
| rd_out_valid | output | 1 | Read result valid |
| limit_clr | input | 1 | Synchronous clear of the limit flag |
| limit_flag | output | 1 | Sticky limit flag |
| wr_valid | input | 1 | Write request |
| wr_dst | input | 2 | Write destination select |
| wr_short | input | 1 | Operand is a short word |
| wr_data | input | DATA_W | Write operand |
| acc_wr_en | output | 1 | Accumulator write strobe |
| acc_wr_data | output | EXT_W+2*DATA_W | Formatted accumulator value |
| reg_wr_en | output | 1 | Data-word register write strobe |
| reg_wr_data | output | DATA_W | Formatted register value |

## Verification
The bench builds the block with EXT_W=2, DATA_W=4 and SHORT_W=3, which gives a 10-bit accumulator. At that size every accumulator value can be read under all four scaling modes and both destination widths. Both clamp directions, the exact boundary values on each side of the clamp, and the shifts that push a value across it are therefore all covered. Every operand is also written to every destination at both operand widths, over several background accumulator values. The small widths keep the guard, high and low parts distinct, so each sign-extension, zero fill and merge can be observed bit by bit.

// File: rtl/acc_move_pkg.sv
// Shared encodings for the accumulator move path.
// Assumes the two-bit select ports of the top module use these codes.
package acc_move_pkg;
    typedef enum logic [1:0] {
        SCALE_NONE = 2'b00,
        SCALE_DOWN = 2'b01,
        SCALE_UP   = 2'b10,
        SCALE_RSVD = 2'b11
    } scale_mode_e;

    typedef enum logic [1:0] {
        RD_FULL = 2'd0,
        RD_EXT  = 2'd1,
        RD_MID  = 2'd2,
        RD_LOW  = 2'd3
    } rd_src_e;

    typedef enum logic [1:0] {
        WR_FULL = 2'd0,
        WR_MID  = 2'd1,
        WR_LOW  = 2'd2,
        WR_REG  = 2'd3
    } wr_dst_e;
endpackage

// File: rtl/acc_scaler.sv
// One-position scaler and guard-bit check for full-accumulator reads.
// Takes only the accumulator bits from the top down to bit DATA_W-1, which is
// all that a shift by one can move into the high-word window. Produces that
// window, the sign, and whether the guard bits are in use after scaling.
// Assumes the accumulator is EXT_W + 2*DATA_W bits wide.
module acc_scaler
    import acc_move_pkg::*;
#(
    parameter int EXT_W  = 8,
    parameter int DATA_W = 24
) (
    input  logic [EXT_W+DATA_W:0] hi_bits,
    input  logic [1:0]            mode,
    output logic [DATA_W-1:0]     window,
    output logic                  sign,
    output logic                  ext_used
);
    localparam int HI_W  = EXT_W + DATA_W + 1;
    localparam int TOP_W = HI_W - DATA_W + 1;

    // One extra sign bit so a left shift keeps the true top bit.
    logic [HI_W:0]     wide;
    // Index k of scaled stands for accumulator bit k+DATA_W-1.
    logic [HI_W:1]     scaled;
    logic [TOP_W-1:0]  top;

    assign wide = {hi_bits[HI_W-1], hi_bits};

    // Select the shifted view according to the scaling mode.
    always_comb begin
        case (scale_mode_e'(mode))
            SCALE_DOWN: scaled = {wide[HI_W], wide[HI_W:2]};
            SCALE_UP:   scaled = wide[HI_W-1:0];
            default:    scaled = wide[HI_W:1];
        endcase
    end

    // The guard bits are in use when the bits above the window's sign are not uniform.
    always_comb begin
        top      = scaled[HI_W:DATA_W];
        ext_used = !((&top) || !(|top));
        window   = scaled[DATA_W:1];
        sign     = scaled[HI_W];
    end
endmodule

// File: rtl/acc_limiter.sv
// Clamp and width selection for the read side.
// Full-source reads are clamped to the extreme data words when the guard bits
// are in use. Sub-register reads pass through untouched. A short destination
// keeps only the low SHORT_W bits of whichever value was chosen.
module acc_limiter #(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic [DATA_W-1:0] window,
    input  logic              sign,
    input  logic              ext_used,
    input  logic              full_src,
    input  logic [DATA_W-1:0] sub_value,
    input  logic              short_dst,
    output logic [DATA_W-1:0] result,
    output logic              sat
);
    localparam logic [DATA_W-1:0] SAT_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SAT_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] SHORT_MASK = DATA_W'((64'd1 << SHORT_W) - 64'd1);

    logic [DATA_W-1:0] base;

    // Choose between the clamp, the scaled window and the sub-register value.
    always_comb begin
        sat = full_src && ext_used;
        if (!full_src)
            base = sub_value;
        else if (sat)
            base = sign ? SAT_NEG : SAT_POS;
        else
            base = window;
        result = short_dst ? (base & SHORT_MASK) : base;
    end
endmodule

// File: rtl/acc_write_fmt.sv
// Write-side operand formatting.
// Zero-fills a short operand to a data word. It then either builds a full
// accumulator value (sign-extended, zero low word), merges the operand into
// one sub-register of the current accumulator, or passes it on to a data-word
// register. Assumes SHORT_W <= DATA_W.
module acc_write_fmt
    import acc_move_pkg::*;
#(
    parameter int EXT_W   = 8,
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic [EXT_W+2*DATA_W-1:0] acc_cur,
    input  logic [DATA_W-1:0]         data,
    input  logic                      short_op,
    input  logic [1:0]                dst,
    output logic [EXT_W+2*DATA_W-1:0] acc_val,
    output logic                      acc_sel,
    output logic [DATA_W-1:0]         reg_val,
    output logic                      reg_sel
);
    logic [DATA_W-1:0] opnd;

    // Zero-fill a short operand; the variant depends on whether there is room.
    generate
        if (SHORT_W < DATA_W) begin : g_fill
            assign opnd = short_op ? {{(DATA_W-SHORT_W){1'b0}}, data[SHORT_W-1:0]} : data;
        end else begin : g_same
            assign opnd = data;
        end
    endgenerate

    // Route the formatted operand to the selected destination.
    always_comb begin
        acc_val = acc_cur;
        acc_sel = 1'b0;
        reg_val = '0;
        reg_sel = 1'b0;
        case (wr_dst_e'(dst))
            WR_FULL: begin
                acc_val = {{EXT_W{opnd[DATA_W-1]}}, opnd, {DATA_W{1'b0}}};
                acc_sel = 1'b1;
            end
            WR_MID: begin
                acc_val[2*DATA_W-1:DATA_W] = opnd;
                acc_sel = 1'b1;
            end
            WR_LOW: begin
                acc_val[DATA_W-1:0] = opnd;
                acc_sel = 1'b1;
            end
            default: begin
                reg_val = opnd;
                reg_sel = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/acc_move_path.sv
// Accumulator move path: scaled and limited reads, formatted writes.
// Both paths are registered once. The limit flag is sticky, with a synchronous
// clear in which a new clamp takes priority. Assumes EXT_W < DATA_W and
// SHORT_W <= DATA_W. acc_in is the live accumulator, used both as the read
// source and as the base for sub-register merges.
module acc_move_path
    import acc_move_pkg::*;
#(
    parameter int EXT_W   = 8,
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                scale_mode,
    input  logic [EXT_W+2*DATA_W-1:0] acc_in,
    input  logic                      rd_valid,
    input  logic [1:0]                rd_src,
    input  logic                      rd_short,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_out_valid,
    input  logic                      limit_clr,
    output logic                      limit_flag,
    input  logic                      wr_valid,
    input  logic [1:0]                wr_dst,
    input  logic                      wr_short,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      acc_wr_en,
    output logic [EXT_W+2*DATA_W-1:0] acc_wr_data,
    output logic                      reg_wr_en,
    output logic [DATA_W-1:0]         reg_wr_data
);
    localparam int ACC_W = EXT_W + 2 * DATA_W;
    localparam logic [DATA_W-1:0] SAT_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] SAT_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] window_c;
    logic              sign_c;
    logic              ext_used_c;
    logic              full_src_c;
    logic [DATA_W-1:0] sub_val_c;
    logic [DATA_W-1:0] rd_res_c;
    logic              rd_sat_c;
    logic [ACC_W-1:0]  acc_val_c;
    logic              acc_sel_c;
    logic [DATA_W-1:0] reg_val_c;
    logic              reg_sel_c;

    logic              rd_sat_q;
    logic              rd_short_q;
    logic [1:0]        wr_dst_q;
    logic              wr_short_q;

    acc_scaler #(.EXT_W(EXT_W), .DATA_W(DATA_W)) u_scaler (
        .hi_bits  (acc_in[ACC_W-1:DATA_W-1]),
        .mode     (scale_mode),
        .window   (window_c),
        .sign     (sign_c),
        .ext_used (ext_used_c)
    );

    // Pick the sub-register value for reads that bypass scaling.
    always_comb begin
        full_src_c = (rd_src == RD_FULL);
        case (rd_src_e'(rd_src))
            RD_EXT:  sub_val_c = {{(DATA_W-EXT_W){acc_in[ACC_W-1]}}, acc_in[ACC_W-1:2*DATA_W]};
            RD_MID:  sub_val_c = acc_in[2*DATA_W-1:DATA_W];
            RD_LOW:  sub_val_c = acc_in[DATA_W-1:0];
            default: sub_val_c = '0;
        endcase
    end

    acc_limiter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_limiter (
        .window    (window_c),
        .sign      (sign_c),
        .ext_used  (ext_used_c),
        .full_src  (full_src_c),
        .sub_value (sub_val_c),
        .short_dst (rd_short),
        .result    (rd_res_c),
        .sat       (rd_sat_c)
    );

    acc_write_fmt #(.EXT_W(EXT_W), .DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_wfmt (
        .acc_cur  (acc_in),
        .data     (wr_data),
        .short_op (wr_short),
        .dst      (wr_dst),
        .acc_val  (acc_val_c),
        .acc_sel  (acc_sel_c),
        .reg_val  (reg_val_c),
        .reg_sel  (reg_sel_c)
    );

    // Register the read result; data holds when no read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data      <= '0;
            rd_out_valid <= 1'b0;
            rd_sat_q     <= 1'b0;
            rd_short_q   <= 1'b0;
        end else begin
            rd_out_valid <= rd_valid;
            if (rd_valid) begin
                rd_data    <= rd_res_c;
                rd_sat_q   <= rd_sat_c;
                rd_short_q <= rd_short;
            end
        end
    end

    // Sticky limit flag: a clamp sets it, a clear resets it, and a clamp wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_flag <= 1'b0;
        else if (rd_valid && rd_sat_c)
            limit_flag <= 1'b1;
        else if (limit_clr)
            limit_flag <= 1'b0;
    end

    // Register the write results and their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_wr_en   <= 1'b0;
            acc_wr_data <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_data <= '0;
            wr_dst_q    <= '0;
            wr_short_q  <= 1'b0;
        end else begin
            acc_wr_en <= wr_valid && acc_sel_c;
            reg_wr_en <= wr_valid && reg_sel_c;
            if (wr_valid) begin
                acc_wr_data <= acc_val_c;
                reg_wr_data <= reg_val_c;
                wr_dst_q    <= wr_dst;
                wr_short_q  <= wr_short;
            end
        end
    end

    // R2
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_sat_q && !rd_short_q) |-> (rd_data == SAT_POS || rd_data == SAT_NEG));

    // R3
    short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_short_q) |-> ((rd_data >> SHORT_W) == '0));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_flag && !limit_clr) |=> limit_flag);

    // R4
    flag_follows_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && rd_sat_q) |-> limit_flag);

    // R6
    sub_read_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_src != RD_FULL && !limit_clr) |=> $stable(limit_flag));

    // R7
    full_write_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_en && wr_dst_q == WR_FULL) |->
        (acc_wr_data[DATA_W-1:0] == '0 &&
         (acc_wr_data[ACC_W-1:2*DATA_W-1] == '0 || (&acc_wr_data[ACC_W-1:2*DATA_W-1]))));

    // R8
    reg_short_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && wr_short_q) |-> ((reg_wr_data >> SHORT_W) == '0));

    // R10
    mid_merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_en && wr_dst_q == WR_MID) |->
        (acc_wr_data[ACC_W-1:2*DATA_W] == $past(acc_in[ACC_W-1:2*DATA_W]) &&
         acc_wr_data[DATA_W-1:0] == $past(acc_in[DATA_W-1:0])));

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr_en && reg_wr_en));
endmodule

// File: tb/acc_move_path_tb.sv
module acc_move_path_tb;
    localparam int EW = 2;
    localparam int DW = 4;
    localparam int SW = 3;
    localparam int AW = EW + 2 * DW;
    localparam int DMASK = (1 << DW) - 1;
    localparam int SMASK = (1 << SW) - 1;
    localparam int AMASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    scale_mode = '0;
    logic [AW-1:0] acc_in = '0;
    logic          rd_valid = 1'b0;
    logic [1:0]    rd_src = '0;
    logic          rd_short = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_out_valid;
    logic          limit_clr = 1'b0;
    logic          limit_flag;
    logic          wr_valid = 1'b0;
    logic [1:0]    wr_dst = '0;
    logic          wr_short = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          acc_wr_en;
    logic [AW-1:0] acc_wr_data;
    logic          reg_wr_en;
    logic [DW-1:0] reg_wr_data;

    int checks = 0;
    int failures = 0;
    bit model_flag = 1'b0;

    always #5 clk = ~clk;

    acc_move_path #(.EXT_W(EW), .DATA_W(DW), .SHORT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .scale_mode(scale_mode), .acc_in(acc_in),
        .rd_valid(rd_valid), .rd_src(rd_src), .rd_short(rd_short),
        .rd_data(rd_data), .rd_out_valid(rd_out_valid),
        .limit_clr(limit_clr), .limit_flag(limit_flag),
        .wr_valid(wr_valid), .wr_dst(wr_dst), .wr_short(wr_short), .wr_data(wr_data),
        .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    // Expected read result and clamp, from the requirement text.
    function automatic void exp_read(input int a, input int mode, input int src, input int shrt,
                                     output int data, output bit sat);
        int v;
        int w;
        int base;
        sat = 1'b0;
        base = 0;
        if (src == 0) begin
            v = sx(a, AW);
            if (mode == 1) v = v >>> 1;
            else if (mode == 2) v = v * 2;
            w = v >>> DW;
            if (w > (1 << (DW - 1)) - 1) begin sat = 1'b1; base = (1 << (DW - 1)) - 1; end
            else if (w < -(1 << (DW - 1))) begin sat = 1'b1; base = 1 << (DW - 1); end
            else base = w & DMASK;
        end else if (src == 1) base = sx(a >> (2 * DW), EW) & DMASK;
        else if (src == 2) base = (a >> DW) & DMASK;
        else base = a & DMASK;
        data = shrt ? (base & SMASK) : base;
    endfunction

    task automatic do_read(input int a, input int mode, input int src, input int shrt, input bit clr);
        int ed;
        bit es;
        string tag;
        @(negedge clk);
        acc_in = AW'(a); scale_mode = 2'(mode); rd_src = 2'(src);
        rd_short = shrt[0]; rd_valid = 1'b1; limit_clr = clr;
        exp_read(a, mode, src, shrt, ed, es);
        if (es) model_flag = 1'b1;
        else if (clr) model_flag = 1'b0;
        @(negedge clk);
        rd_valid = 1'b0; limit_clr = 1'b0;
        if (src != 0) tag = "R6";
        else if (shrt != 0) tag = "R3";
        else if (es) tag = "R2";
        else tag = "R1";
        check(tag, int'(rd_data), ed);
        check("R11 rd_out_valid", int'(rd_out_valid), 1);
        if (src != 0) check("R6 flag", int'(limit_flag), int'(model_flag));
        else if (clr) check("R5 flag", int'(limit_flag), int'(model_flag));
        else check("R4 flag", int'(limit_flag), int'(model_flag));
    endtask

    task automatic do_write(input int a, input int d, input int dst, input int shrt);
        int m;
        int ea;
        int top;
        string tag;
        @(negedge clk);
        acc_in = AW'(a); wr_data = DW'(d); wr_dst = 2'(dst); wr_short = shrt[0]; wr_valid = 1'b1;
        m = shrt != 0 ? (d & SMASK) : d;
        ea = 0;
        if (dst == 0) begin
            top = ((m >> (DW - 1)) & 1) != 0 ? (1 << EW) - 1 : 0;
            ea = (top << (2 * DW)) | (m << DW);
        end else if (dst == 1) ea = ((a & ~(DMASK << DW)) | (m << DW)) & AMASK;
        else if (dst == 2) ea = ((a & ~DMASK) | m) & AMASK;
        @(negedge clk);
        wr_valid = 1'b0;
        if (dst == 0) tag = shrt != 0 ? "R9" : "R7";
        else if (dst == 3) tag = "R8";
        else tag = shrt != 0 ? "R8" : "R10";
        check("R11 acc_wr_en", int'(acc_wr_en), dst != 3 ? 1 : 0);
        check("R11 reg_wr_en", int'(reg_wr_en), dst == 3 ? 1 : 0);
        if (dst != 3) check(tag, int'(acc_wr_data), ea);
        else check(tag, int'(reg_wr_data), m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 rd_data", int'(rd_data), 0);
        check("R11 rd_out_valid", int'(rd_out_valid), 0);
        check("R11 limit_flag", int'(limit_flag), 0);
        check("R11 acc_wr_en", int'(acc_wr_en), 0);
        check("R11 acc_wr_data", int'(acc_wr_data), 0);
        check("R11 reg_wr_en", int'(reg_wr_en), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5: every value, mode and width for full reads
        for (int mode = 0; mode < 4; mode++)
            for (int sh = 0; sh < 2; sh++)
                for (int a = 0; a < (1 << AW); a++)
                    do_read(a, mode, 0, sh, (a % 97) == 5);

        // R5: clear with no read, then clamp and clear together
        @(negedge clk); limit_clr = 1'b1;
        @(negedge clk); limit_clr = 1'b0; model_flag = 1'b0;
        check("R5 clear", int'(limit_flag), 0);
        do_read(1 << (AW - 2), 0, 0, 0, 1'b1);
        check("R5 clamp beats clear", int'(limit_flag), 1);

        // R4: a clamping value without rd_valid has no effect
        @(negedge clk); limit_clr = 1'b1;
        @(negedge clk); limit_clr = 1'b0; model_flag = 1'b0;
        acc_in = AW'(1 << (AW - 2)); scale_mode = 2'd0; rd_src = 2'd0;
        @(negedge clk);
        check("R4 idle flag", int'(limit_flag), 0);
        check("R4 idle valid", int'(rd_out_valid), 0);

        // R6: sub-register sources, scaling mode varied
        for (int src = 1; src < 4; src++)
            for (int sh = 0; sh < 2; sh++)
                for (int a = 0; a < (1 << AW); a++)
                    do_read(a, a % 4, src, sh, 1'b0);

        // R7 R8 R9 R10: every operand into every destination
        for (int dst = 0; dst < 4; dst++)
            for (int sh = 0; sh < 2; sh++)
                for (int d = 0; d < (1 << DW); d++)
                    for (int k = 0; k < 3; k++)
                        do_write(((d * 37 + k * 301) ^ 16'h2A5) & AMASK, d, dst, sh);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule